// File: doc/BRIEF.md
# Conversion Request Arbiter with Lock

This block decides which of several conversion request sources an analog-to-digital converter serves next. Every source keeps a count of outstanding requests per channel. Each source has a programmable two-bit arbitration level and a fixed check position, which is its index. One source, at a parameterised position, is the timer source. While the converter is idle the block runs one arbitration cycle per clock. If a source wins, the block issues a one-cycle start strobe together with the source number and the channel. It then waits for the converter's done pulse, which removes one request from the served channel.

The timer source can be made to take part in arbitration even when it has nothing pending. A lock flag does this: the flag is set when lock mode is enabled and the down-counting timer value is at or below a boundary. Sources ranked under the timer then cannot start. A synchronized-injection request from a master converter takes no part in arbitration. It is latched and served before anything else, and it stays until its conversion is done or the master cancels it.

Top module: `crq_arbiter`

## Requirements
- R1: Each one-cycle pulse on bit s*NUM_CH+c of `req_set_i` adds one pending request for source s, channel c. A channel with k pending requests is converted k times, with one start strobe per conversion.
- R2: A start strobe is issued only while no conversion is in flight. It lasts exactly one cycle. The next strobe can come no earlier than the second rising edge after `conv_done_i` is sampled high.
- R3: Among taking-part sources, the higher level wins. The level of source s is `src_lvl_i[2s+1:2s]`. At equal levels, the lower source index (the earlier check position) wins.
- R4: The lock flag is registered. It is set one cycle after `lock_en_i` is high while `tmr_val_i <= lock_bnd_i`, and it is clear otherwise. When `lock_en_i` is low, the timer source has no effect unless it has requests pending.
- R5: The timer source (index TMR_POS, default 2) takes part if it has any pending request or if the lock flag is set. If it wins with nothing pending, no strobe is issued, and every source with a lower level, or with an equal level and a later check position, stays blocked.
- R6: While the timer blocks, a source with a higher level than the timer, or with an equal level and an earlier check position, still wins and starts normally.
- R7: A pulse on `inj_req_i` latches an injection for channel `inj_ch_i`. While idle, a latched injection starts on the next edge with `win_src_o` = NUM_SRC (5 by default), regardless of levels, pending requests or lock.
- R8: A latched injection is cleared by the done pulse of its own conversion, or by `inj_cancel_i`. A cancelled injection is never started.
- R9: Within the winning source, the lowest-numbered channel with pending requests is converted first. Only the done pulse ends a conversion, and it removes exactly one request of the served source and channel.
- R10: A synchronous high `rst` clears all pending counts, the lock flag, the injection latch and all outputs to zero.
- R11: A `conv_done_i` pulse while no conversion is in flight changes no pending count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_set_i | input | NUM_SRC*NUM_CH | Per-source, per-channel request pulses |
| src_lvl_i | input | NUM_SRC*LVL_W | Arbitration level of each source |
| lock_en_i | input | 1 | Lock mode enable |
| tmr_val_i | input | TMR_W | Current down-counting timer value |
| lock_bnd_i | input | TMR_W | Lock boundary |
| inj_req_i | input | 1 | Synchronized-injection request pulse |
| inj_ch_i | input | CH_W | Channel of the injection |
| inj_cancel_i | input | 1 | Cancels a latched injection |
| conv_done_i | input | 1 | Converter done pulse |
| start_o | output | 1 | One-cycle start-conversion strobe |
| win_src_o | output | SRC_W | Winning source, NUM_SRC for injection |
| win_ch_o | output | CH_W | Channel to convert |

## Verification
A request pulse sampled on one rising edge updates the pending counts on that edge. The strobe for it is registered on the next edge, so with an idle converter it is visible one clock after the pulse was sampled. The lock flag adds one more register stage, so the bench waits several cycles after changing the timer inputs before it loads requests. A done pulse returns the block to idle, and the following edge may start the next conversion. The bench drives inputs and samples outputs on falling edges. A scoreboard matches each strobe against the queued source and channel whenever it appears, so the checks do not depend on exact latency. Windows with no strobe are checked by comparing a strobe counter before and after a fixed idle stretch.

// File: rtl/crq_pkg.sv
package crq_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} crq_state_e;
endpackage

// File: rtl/crq_pend_store.sv
module crq_pend_store #(
  parameter int NUM_SRC = 5,
  parameter int NUM_CH  = 8,
  parameter int CNT_W   = 2,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SRC_W  = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC*NUM_CH-1:0] set_i,
  input  logic                      dec_en_i,
  input  logic [SRC_W-1:0]          dec_src_i,
  input  logic [CH_W-1:0]           dec_ch_i,
  output logic [NUM_SRC-1:0]        any_o,
  output logic [NUM_SRC*CH_W-1:0]   first_ch_o
);
  localparam int NSLOT = NUM_SRC * NUM_CH;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [NSLOT];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int IDX = s * NUM_CH + c;
      logic inc, dec;
      assign inc = set_i[IDX];
      assign dec = dec_en_i && (dec_src_i == SRC_W'(s)) && (dec_ch_i == CH_W'(c));
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q[IDX] <= '0;
        end else if (inc && !dec && cnt_q[IDX] != CNT_MAX) begin
          cnt_q[IDX] <= cnt_q[IDX] + 1'b1;
        end else if (dec && !inc && cnt_q[IDX] != '0) begin
          cnt_q[IDX] <= cnt_q[IDX] - 1'b1;
        end
      end
    end

    always_comb begin
      any_o[s] = 1'b0;
      first_ch_o[s*CH_W +: CH_W] = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
        if (cnt_q[s*NUM_CH + c] != '0) begin
          any_o[s] = 1'b1;
          first_ch_o[s*CH_W +: CH_W] = CH_W'(c);
        end
      end
    end
  end
endmodule

// File: rtl/crq_lock_flag.sv
module crq_lock_flag #(
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [TMR_W-1:0] val_i,
  input  logic [TMR_W-1:0] bnd_i,
  output logic             lock_o
);
  always_ff @(posedge clk) begin
    if (rst) lock_o <= 1'b0;
    else     lock_o <= en_i && (val_i <= bnd_i);
  end
endmodule

// File: rtl/crq_level_pick.sv
module crq_level_pick #(
  parameter int NUM_SRC = 5,
  parameter int LVL_W   = 2,
  localparam int SRC_W  = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0]       part_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
  output logic                     found_o,
  output logic [SRC_W-1:0]         win_o
);
  logic [LVL_W-1:0] best;
  always_comb begin
    found_o = 1'b0;
    win_o   = '0;
    best    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (part_i[i] && (!found_o || lvl_i[i*LVL_W +: LVL_W] > best)) begin
        found_o = 1'b1;
        win_o   = SRC_W'(i);
        best    = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/crq_arbiter.sv
module crq_arbiter
  import crq_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int TMR_POS = 2,
  parameter int NUM_CH  = 8,
  parameter int LVL_W   = 2,
  parameter int CNT_W   = 2,
  parameter int TMR_W   = 12,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SRC_W  = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC*NUM_CH-1:0] req_set_i,
  input  logic [NUM_SRC*LVL_W-1:0]  src_lvl_i,
  input  logic                      lock_en_i,
  input  logic [TMR_W-1:0]          tmr_val_i,
  input  logic [TMR_W-1:0]          lock_bnd_i,
  input  logic                      inj_req_i,
  input  logic [CH_W-1:0]           inj_ch_i,
  input  logic                      inj_cancel_i,
  input  logic                      conv_done_i,
  output logic                      start_o,
  output logic [SRC_W-1:0]          win_src_o,
  output logic [CH_W-1:0]           win_ch_o
);
  localparam logic [SRC_W-1:0] INJ_CODE = SRC_W'(NUM_SRC);

  crq_state_e             state_q;
  logic                   inj_q, srv_inj_q;
  logic [CH_W-1:0]        inj_ch_q;
  logic [NUM_SRC-1:0]     any_w, part_w;
  logic [NUM_SRC*CH_W-1:0] first_ch_w;
  logic                   lock_q, found_w, win_pend_w, dec_en_w, busy_w, tmr_any_w;
  logic [SRC_W-1:0]       win_w;
  logic [CH_W-1:0]        win_ch_w;

  assign busy_w   = (state_q == ST_BUSY);
  assign dec_en_w = busy_w && conv_done_i && !srv_inj_q;
  assign tmr_any_w = any_w[TMR_POS];

  crq_pend_store #(.NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rst(rst), .set_i(req_set_i),
    .dec_en_i(dec_en_w), .dec_src_i(win_src_o), .dec_ch_i(win_ch_o),
    .any_o(any_w), .first_ch_o(first_ch_w)
  );

  crq_lock_flag #(.TMR_W(TMR_W)) lock_i (
    .clk(clk), .rst(rst), .en_i(lock_en_i),
    .val_i(tmr_val_i), .bnd_i(lock_bnd_i), .lock_o(lock_q)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_part
    if (s == TMR_POS) begin : g_tmr
      assign part_w[s] = any_w[s] | lock_q;
    end else begin : g_reg
      assign part_w[s] = any_w[s];
    end
  end

  crq_level_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) pick_i (
    .part_i(part_w), .lvl_i(src_lvl_i), .found_o(found_w), .win_o(win_w)
  );

  always_comb begin
    win_pend_w = 1'b0;
    win_ch_w   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (win_w == SRC_W'(i)) begin
        win_pend_w = any_w[i];
        win_ch_w   = first_ch_w[i*CH_W +: CH_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inj_q    <= 1'b0;
      inj_ch_q <= '0;
    end else if (inj_cancel_i) begin
      inj_q <= 1'b0;
    end else if (inj_req_i) begin
      inj_q    <= 1'b1;
      inj_ch_q <= inj_ch_i;
    end else if (busy_w && conv_done_i && srv_inj_q) begin
      inj_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      srv_inj_q <= 1'b0;
      start_o   <= 1'b0;
      win_src_o <= '0;
      win_ch_o  <= '0;
    end else begin
      start_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (inj_q && !inj_cancel_i) begin
            start_o   <= 1'b1;
            win_src_o <= INJ_CODE;
            win_ch_o  <= inj_ch_q;
            srv_inj_q <= 1'b1;
            state_q   <= ST_BUSY;
          end else if (found_w && win_pend_w) begin
            start_o   <= 1'b1;
            win_src_o <= win_w;
            win_ch_o  <= win_ch_w;
            srv_inj_q <= 1'b0;
            state_q   <= ST_BUSY;
          end
        end
        default: begin
          if (conv_done_i) state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/crq_arbiter_chk.sv
module crq_arbiter_chk #(
  parameter int NUM_SRC = 5,
  parameter int TMR_POS = 2,
  localparam int SRC_W  = $clog2(NUM_SRC + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start_o,
  input logic [SRC_W-1:0] win_src_o,
  input logic             busy_w,
  input logic             inj_q,
  input logic             inj_cancel_i,
  input logic             conv_done_i,
  input logic             tmr_any_w
);
  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R2
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_w && !conv_done_i) |=> !start_o); // R2
  AST_INJ_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!busy_w && inj_q && !inj_cancel_i) |=> (start_o && win_src_o == SRC_W'(NUM_SRC))); // R7
  AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    inj_cancel_i |=> !inj_q); // R8
  AST_TIMER_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    (start_o && win_src_o == SRC_W'(TMR_POS)) |-> $past(tmr_any_w)); // R5
endmodule

bind crq_arbiter crq_arbiter_chk #(.NUM_SRC(NUM_SRC), .TMR_POS(TMR_POS)) chk_i (
  .clk(clk), .rst(rst), .start_o(start_o), .win_src_o(win_src_o),
  .busy_w(busy_w), .inj_q(inj_q), .inj_cancel_i(inj_cancel_i),
  .conv_done_i(conv_done_i), .tmr_any_w(tmr_any_w)
);

// File: tb/crq_arbiter_tb_top.sv
module crq_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 5, NCH = 8, LW = 2, TW = 12, DLAT = 4;
  localparam int CW = $clog2(NCH), SW = $clog2(NSRC + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic [NSRC*NCH-1:0] req_set = '0;
  logic [NSRC*LW-1:0]  lvl = '0;
  logic lock_en = 1'b0, inj_req = 1'b0, inj_cancel = 1'b0;
  logic [TW-1:0] tmr_val = '0, lock_bnd = '0;
  logic [CW-1:0] inj_ch = '0;
  logic model_done = 1'b0, man_done = 1'b0;
  logic start;
  logic [SW-1:0] win_src;
  logic [CW-1:0] win_ch;

  int tests = 0, fails = 0, start_cnt = 0;
  bit finished = 0;
  int q_src[$], q_ch[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  crq_arbiter dut_i (
    .clk(clk), .rst(rst), .req_set_i(req_set), .src_lvl_i(lvl),
    .lock_en_i(lock_en), .tmr_val_i(tmr_val), .lock_bnd_i(lock_bnd),
    .inj_req_i(inj_req), .inj_ch_i(inj_ch), .inj_cancel_i(inj_cancel),
    .conv_done_i(model_done | man_done),
    .start_o(start), .win_src_o(win_src), .win_ch_o(win_ch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_win(input int s, input int c, input string tag);
    q_src.push_back(s); q_ch.push_back(c); q_tag.push_back(tag);
  endtask

  // monitor: compare each strobe with the scoreboard head
  always @(negedge clk) begin
    if (!rst && start) begin
      start_cnt++;
      if (q_src.size() == 0) begin
        chk(0, "R2 unexpected start src", int'(win_src), -1);
      end else begin
        int es, ec; string t;
        es = q_src.pop_front(); ec = q_ch.pop_front(); t = q_tag.pop_front();
        chk(int'(win_src) == es, {t, " src"}, int'(win_src), es);
        chk(int'(win_ch) == ec,  {t, " ch"},  int'(win_ch),  ec);
      end
    end
  end

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (start) begin
        repeat (DLAT) @(negedge clk);
        model_done = 1'b1;
        @(negedge clk);
        model_done = 1'b0;
      end
    end
  end

  task automatic set_lvl(input int l0, input int l1, input int l2, input int l3, input int l4);
    lvl = {LW'(l4), LW'(l3), LW'(l2), LW'(l1), LW'(l0)};
  endtask

  task automatic pulse(input logic [NSRC*NCH-1:0] v);
    req_set = v;
    @(negedge clk);
    req_set = '0;
  endtask

  function automatic logic [NSRC*NCH-1:0] bitof(input int s, input int c);
    logic [NSRC*NCH-1:0] v = '0;
    v[s*NCH + c] = 1'b1;
    return v;
  endfunction

  task automatic drain();
    for (int i = 0; i < 2000 && q_src.size() != 0; i++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(q_src.size() == 0, "R1 scoreboard drained", q_src.size(), 0);
  endtask

  task automatic quiet(input string tag);
    int n0 = start_cnt;
    repeat (20) @(negedge clk);
    chk(start_cnt == n0, tag, start_cnt - n0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(start == 1'b0, "R10 start after reset", int'(start), 0);
    chk(win_src == '0, "R10 src after reset", int'(win_src), 0);
    chk(win_ch == '0, "R10 ch after reset", int'(win_ch), 0);

    // R3: level order, equal level resolved by check position
    set_lvl(1, 2, 0, 2, 3);
    expect_win(4, 2, "R3 highest level");
    expect_win(1, 5, "R3 tie earlier position");
    expect_win(3, 1, "R3 tie later position");
    expect_win(0, 3, "R3 lowest level");
    pulse(bitof(0, 3) | bitof(1, 5) | bitof(3, 1) | bitof(4, 2));
    drain();

    // R1 / R9: repeated channel, lowest channel first
    expect_win(1, 2, "R9 lowest channel first");
    expect_win(1, 2, "R1 repeat same channel");
    expect_win(1, 6, "R9 higher channel after");
    pulse(bitof(1, 2) | bitof(1, 6));
    pulse(bitof(1, 2));
    drain();

    // R5: timer with a pending request starts; equal level later waits
    set_lvl(0, 0, 2, 2, 0);
    expect_win(2, 3, "R5 timer with pending");
    expect_win(3, 2, "R3 after timer");
    pulse(bitof(2, 3) | bitof(3, 2));
    drain();

    // R4 / R5 / R6 / R11: lock blocks lower and equal-later sources
    set_lvl(1, 2, 2, 2, 3);
    lock_en = 1'b1; tmr_val = 12'd5; lock_bnd = 12'd10;
    repeat (3) @(negedge clk);
    pulse(bitof(0, 0) | bitof(3, 1));
    quiet("R5 lock blocks lower and equal-later");
    man_done = 1'b1; @(negedge clk); man_done = 1'b0;
    quiet("R11 stray done starts nothing");
    expect_win(4, 4, "R6 higher level beats lock");
    pulse(bitof(4, 4));
    drain();
    expect_win(1, 7, "R6 equal level earlier beats lock");
    pulse(bitof(1, 7));
    drain();
    expect_win(3, 1, "R4 lock released");
    expect_win(0, 0, "R11 pending kept across stray done");
    tmr_val = 12'd20;
    drain();

    // R4: lock mode disabled, timer below boundary has no effect
    lock_en = 1'b0; tmr_val = 12'd5;
    repeat (3) @(negedge clk);
    expect_win(0, 2, "R4 no lock when disabled");
    pulse(bitof(0, 2));
    drain();

    // R7: injection beats pending request and runs once
    inj_ch = 3'd5; inj_req = 1'b1;
    expect_win(NSRC, 5, "R7 injection first");
    expect_win(0, 1, "R8 served injection not repeated");
    pulse(bitof(0, 1));
    inj_req = 1'b0;
    drain();

    // R7 under lock
    lock_en = 1'b1;
    repeat (3) @(negedge clk);
    inj_ch = 3'd3; inj_req = 1'b1;
    expect_win(NSRC, 3, "R7 injection ignores lock");
    @(negedge clk); inj_req = 1'b0;
    drain();
    lock_en = 1'b0;
    repeat (3) @(negedge clk);

    // R8: cancel a latched injection before it is served
    begin
      int n0;
      expect_win(0, 1, "R8 carrier conversion");
      n0 = start_cnt;
      pulse(bitof(0, 1));
      for (int i = 0; i < 50 && start_cnt == n0; i++) @(negedge clk);
      inj_ch = 3'd6; inj_req = 1'b1;
      @(negedge clk); inj_req = 1'b0; inj_cancel = 1'b1;
      @(negedge clk); inj_cancel = 1'b0;
      drain();
      chk(start_cnt == n0 + 1, "R8 cancelled injection never starts", start_cnt - n0, 1);
    end

    // R2: strobe count equals conversions and no leftovers
    quiet("R2 idle with nothing pending");

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule